// File: doc/BRIEF.md
# Prescaled Match Timer

A 32-bit up-counter behind a prescaler, with four compare channels. The counter advances on every clock, or on rising, falling or both edges of one chosen external input. The prescaler stretches the step: with prescale value P the counter moves once per P+1 qualifying events. Each compare channel watches the count and, when the counter steps away from that channel's value, it can reload the counter with zero, halt the timer, raise a sticky interrupt flag, and clear, set or toggle its own external output bit.

Software reaches every setting through a plain single-cycle write port and a combinational read port indexed by a 4-bit word address. A typical use is a periodic tick: one channel reloads the counter at the period value while the others toggle or set output bits at chosen phases.

Top module: `mtmr_top`

## Requirements
- R1: After reset the count, the prescale counter, the run bit, the clear bit, the mode, the input select, the prescale value, all flags, all output bits and `irq` are 0.
- R2: In mode 0 (control bits [3:2] = 0) with prescale 0, the count rises by one on each clock edge at which the run bit (control bit 0, address 0) was 1, and holds while the run bit is 0.
- R3: With prescale value P (address 1), the count advances once for every P+1 qualifying events, counted from the last clear.
- R4: Control bits [3:2] = 1, 2 or 3 count rising, falling or both edges of `cap_in[sel]`, where sel is control bits [5:4]. Edges on the other inputs have no effect on the count.
- R5: While the clear bit (control bit 1) is 1, the count and the prescale counter are held at 0, even if the run bit is 1.
- R6: A match on channel n happens on a counter step taken while the count equals match value n (address 8+n). If the channel's reload bit (bit 5n+1 of address 6) is 1, that step loads 0 instead of count+1.
- R7: If the channel's halt bit (bit 5n+2 of address 6) is 1, a match clears the run bit and the count stays at the match value.
- R8: If the channel's flag-enable bit (bit 5n of address 6) is 1, a match sets flag n (bit n of address 4). `irq` is the OR of the flags. Writing 1 to a flag bit clears it, writing 0 leaves it.
- R9: On a match, output bit n follows the action field (bits [5n+4:5n+3] of address 6): 0 keeps, 1 clears, 2 sets, 3 toggles it.
- R10: A write to address 5 bits [3:0] loads the output bits with their starting values, and the value reads back there.
- R11: Reads return control at 0, prescale at 1, count at 2, flags at 4, output bits at 5, channel settings at 6 and match value n at 8+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 4 | Word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| cap_in | input | 4 | External event inputs |
| count | output | 32 | Current count |
| ext_match | output | 4 | Match-driven output bits |
| irq | output | 1 | OR of the match flags |

## Verification
The checker takes for granted that the count, the run bit, the flags and the output bits change only through a counter step, a match or a register write, so its properties name the write address that would excuse a change. The inputs on `cap_in` are asynchronous; the properties assume nothing about them, but counting is only exact when each level is held for at least two clocks, and the stimulus holds every pulse level for two clocks. Register writes are placed while the timer is stopped or away from match steps, so no write collides with a match on the same edge.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [1:0] {
        CM_TICK = 2'd0,
        CM_RISE = 2'd1,
        CM_FALL = 2'd2,
        CM_BOTH = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        MA_KEEP   = 2'd0,
        MA_CLEAR  = 2'd1,
        MA_SET    = 2'd2,
        MA_TOGGLE = 2'd3
    } match_act_e;

    // Per-channel settings, packed LSB first: flag enable, reload, halt, action
    typedef struct packed {
        match_act_e act;
        logic       halt_en;
        logic       zero_en;
        logic       flag_en;
    } match_cfg_t;

    localparam int CFG_W   = $bits(match_cfg_t);

    localparam int A_CTRL  = 0;
    localparam int A_PRESC = 1;
    localparam int A_COUNT = 2;
    localparam int A_FLAGS = 4;
    localparam int A_EXT   = 5;
    localparam int A_MCFG  = 6;
    localparam int A_MVAL0 = 8;

    function automatic logic apply_act(match_act_e a, logic cur);
        case (a)
            MA_CLEAR:  return 1'b0;
            MA_SET:    return 1'b1;
            MA_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/mtmr_evt_sel.sv
module mtmr_evt_sel
    import mtmr_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] cap_in,
    input  logic [SEL_W-1:0]  sel,
    input  cnt_mode_e         mode,
    output logic              evt
);
    logic [NUM_IN-1:0] sync1_q, sync2_q, prev_q;
    logic cur, old;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= cap_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign cur = sync2_q[sel];
    assign old = prev_q[sel];

    always_comb begin
        case (mode)
            CM_RISE: evt = cur & ~old;
            CM_FALL: evt = ~cur & old;
            CM_BOTH: evt = cur ^ old;
            default: evt = 1'b1;
        endcase
    end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             load_zero,
    input  logic             hold,
    input  logic [CNT_W-1:0] presc,
    output logic             adv,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] pc_q, tc_q;

    assign adv   = tick && !clr && (pc_q >= presc);
    assign count = tc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc_q <= '0;
            tc_q <= '0;
        end else if (tick) begin
            if (adv) begin
                pc_q <= '0;
                if (load_zero)  tc_q <= '0;
                else if (!hold) tc_q <= tc_q + 1'b1;
            end else begin
                pc_q <= pc_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mtmr_match_bank.sv
module mtmr_match_bank #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4
) (
    input  logic [CNT_W-1:0]     count,
    input  logic                 adv,
    input  logic [CNT_W-1:0]     mval [NUM_MATCH],
    output logic [NUM_MATCH-1:0] hit
);
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        assign hit[g] = adv && (count == mval[g]);
    end
endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4,
    parameter int NUM_IN    = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     rd_data,
    input  logic [NUM_IN-1:0]    cap_in,
    output logic [CNT_W-1:0]     count,
    output logic [NUM_MATCH-1:0] ext_match,
    output logic                 irq
);
    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    logic                 run_q, clr_q;
    cnt_mode_e            mode_q;
    logic [SEL_W-1:0]     sel_q;
    logic [CNT_W-1:0]     presc_q;
    match_cfg_t           cfg_q  [NUM_MATCH];
    logic [CNT_W-1:0]     mval_q [NUM_MATCH];
    logic [NUM_MATCH-1:0] flag_q, ext_q;

    logic evt, adv, load_zero, stop_hit;
    logic [NUM_MATCH-1:0] hit, zero_mask, halt_mask, flag_mask;
    logic wr_ctrl, wr_presc, wr_flags, wr_ext, wr_mcfg;

    assign wr_ctrl  = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_presc = wr_en && (addr == ADDR_W'(A_PRESC));
    assign wr_flags = wr_en && (addr == ADDR_W'(A_FLAGS));
    assign wr_ext   = wr_en && (addr == ADDR_W'(A_EXT));
    assign wr_mcfg  = wr_en && (addr == ADDR_W'(A_MCFG));

    mtmr_evt_sel #(.NUM_IN(NUM_IN), .SEL_W(SEL_W)) u_evt (
        .clk(clk), .rst(rst), .cap_in(cap_in), .sel(sel_q), .mode(mode_q), .evt(evt)
    );

    mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr_q), .tick(run_q && evt),
        .load_zero(load_zero), .hold(stop_hit), .presc(presc_q),
        .adv(adv), .count(count)
    );

    mtmr_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match (
        .count(count), .adv(adv), .mval(mval_q), .hit(hit)
    );

    always_comb begin
        for (int n = 0; n < NUM_MATCH; n++) begin
            zero_mask[n] = cfg_q[n].zero_en;
            halt_mask[n] = cfg_q[n].halt_en;
            flag_mask[n] = cfg_q[n].flag_en;
        end
    end

    assign load_zero = |(hit & zero_mask);
    assign stop_hit  = |(hit & halt_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            clr_q   <= 1'b0;
            mode_q  <= CM_TICK;
            sel_q   <= '0;
            presc_q <= '0;
            flag_q  <= '0;
            ext_q   <= '0;
            for (int n = 0; n < NUM_MATCH; n++) begin
                cfg_q[n]  <= '0;
                mval_q[n] <= '0;
            end
        end else begin
            if (wr_ctrl) begin
                run_q  <= wr_data[0];
                clr_q  <= wr_data[1];
                mode_q <= cnt_mode_e'(wr_data[3:2]);
                sel_q  <= wr_data[4 +: SEL_W];
            end else if (stop_hit) begin
                run_q <= 1'b0;
            end
            if (wr_presc) presc_q <= wr_data;
            flag_q <= (flag_q & ~(wr_flags ? wr_data[NUM_MATCH-1:0] : '0)) | (hit & flag_mask);
            for (int n = 0; n < NUM_MATCH; n++) begin
                if (hit[n])      ext_q[n] <= apply_act(cfg_q[n].act, ext_q[n]);
                else if (wr_ext) ext_q[n] <= wr_data[n];
                if (wr_mcfg) cfg_q[n] <= match_cfg_t'(wr_data[n*CFG_W +: CFG_W]);
                if (wr_en && addr == ADDR_W'(A_MVAL0 + n)) mval_q[n] <= wr_data;
            end
        end
    end

    assign ext_match = ext_q;
    assign irq       = |flag_q;

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(A_CTRL)) begin
            rd_data[0]          = run_q;
            rd_data[1]          = clr_q;
            rd_data[3:2]        = mode_q;
            rd_data[4 +: SEL_W] = sel_q;
        end else if (addr == ADDR_W'(A_PRESC)) begin
            rd_data = presc_q;
        end else if (addr == ADDR_W'(A_COUNT)) begin
            rd_data = count;
        end else if (addr == ADDR_W'(A_FLAGS)) begin
            rd_data[NUM_MATCH-1:0] = flag_q;
        end else if (addr == ADDR_W'(A_EXT)) begin
            rd_data[NUM_MATCH-1:0] = ext_q;
        end else if (addr == ADDR_W'(A_MCFG)) begin
            for (int n = 0; n < NUM_MATCH; n++) rd_data[n*CFG_W +: CFG_W] = cfg_q[n];
        end else begin
            for (int n = 0; n < NUM_MATCH; n++)
                if (addr == ADDR_W'(A_MVAL0 + n)) rd_data = mval_q[n];
        end
    end
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk
    import mtmr_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 4,
    parameter int ADDR_W    = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [CNT_W-1:0]     count,
    input logic                 irq,
    input logic [NUM_MATCH-1:0] ext_match,
    input logic                 run_q,
    input logic                 clr_q,
    input logic                 adv,
    input logic                 stop_hit
);
    logic wr_ctrl_c, wr_flags_c, wr_ext_c;
    assign wr_ctrl_c  = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_flags_c = wr_en && (addr == ADDR_W'(A_FLAGS));
    assign wr_ext_c   = wr_en && (addr == ADDR_W'(A_EXT));

    // R5
    clr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> (count == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !clr_q) |=> $stable(count));

    // R6
    step_size_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_q |=> ((count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0)));

    // R7
    halt_run_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_hit && !wr_ctrl_c) |=> !run_q);

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_flags_c) |=> irq);

    // R9
    ext_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv && !wr_ext_c) |=> $stable(ext_match));
endmodule

bind mtmr_top mtmr_chk #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .count(count), .irq(irq),
    .ext_match(ext_match), .run_q(run_q), .clr_q(clr_q), .adv(adv), .stop_hit(stop_hit)
);

// File: tb/mtmr_top_tb.sv
module mtmr_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  cap_in = '0;
    logic [31:0] count;
    logic [3:0]  ext_match;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtmr_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .cap_in(cap_in), .count(count), .ext_match(ext_match), .irq(irq)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] sel;
        logic [7:0] presc;
        logic [7:0] pulses;
        logic [7:0] expect_cnt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd1, 2'd0, 8'd0, 8'd5, 8'd5},
        '{2'd2, 2'd1, 8'd0, 8'd4, 8'd4},
        '{2'd3, 2'd2, 8'd0, 8'd3, 8'd6},
        '{2'd1, 2'd3, 8'd1, 8'd7, 8'd3},
        '{2'd3, 2'd0, 8'd2, 8'd5, 8'd3},
        '{2'd2, 2'd2, 8'd3, 8'd9, 8'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(a);
        #1 d = rd_data;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); cap_in[idx] = 1'b1;
        @(negedge clk);
        @(negedge clk); cap_in[idx] = 1'b0;
        @(negedge clk);
    endtask

    // clear, run for K idle negedges, stop: K+2 qualifying clocks in mode 0
    task automatic run_for(input int k);
        wr(0, 32'h2);
        wr(0, 32'h1);
        repeat (k) @(negedge clk);
        wr(0, 32'h0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, d); check("R1 control", d, 0);
        rd(1, d); check("R1 prescale", d, 0);
        rd(2, d); check("R1 count", d, 0);
        rd(4, d); check("R1 flags", d, 0);
        check("R1 ext_match", {28'd0, ext_match}, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R11 read map
        wr(1, 32'h1234); rd(1, d); check("R11 prescale readback", d, 32'h1234);
        wr(9, 32'h55); rd(9, d); check("R11 match1 readback", d, 32'h55);
        wr(1, 32'h0);

        // R2 mode 0 counting, then hold while stopped
        run_for(10);
        rd(2, d); check("R2 count after 12 clocks", d, 12);
        repeat (5) @(negedge clk);
        rd(2, d); check("R2 hold while stopped", d, 12);

        // R3 prescale
        wr(1, 32'h2); run_for(10);
        rd(2, d); check("R3 prescale 2", d, 4);
        wr(1, 32'h3); run_for(8);
        rd(2, d); check("R3 prescale 3", d, 2);
        // R5 clear also empties the prescale counter
        run_for(0);
        rd(2, d); check("R5 prescale counter cleared", d, 0);
        wr(1, 32'h0);
        wr(0, 32'h3);
        repeat (5) @(negedge clk);
        rd(2, d); check("R5 clear overrides run", d, 0);
        wr(0, 32'h0);

        // R4 edge modes from the vector table, with noise on a neighbour input
        for (int i = 0; i < 6; i++) begin
            logic [31:0] cw;
            cw = {26'd0, VECS[i].sel, VECS[i].mode, 2'b00};
            wr(1, {24'd0, VECS[i].presc});
            wr(0, cw | 32'h2);
            wr(0, cw | 32'h1);
            for (int j = 0; j < 3; j++) pulse(int'(2'(VECS[i].sel + 2'd1)));
            for (int j = 0; j < int'(VECS[i].pulses); j++) pulse(int'(VECS[i].sel));
            repeat (6) @(negedge clk);
            rd(2, d); check($sformatf("R4 R3 edge vector %0d", i), d, {24'd0, VECS[i].expect_cnt});
            wr(0, 32'h0);
        end
        wr(1, 32'h0);

        // R10 starting output values
        wr(5, 32'hC); rd(5, d); check("R10 ext readback", d, 32'hC);

        // R6 R8 R9 channel settings and matches
        wr(6, 32'hA23A);
        wr(8, 32'd4); wr(9, 32'd2); wr(10, 32'd3); wr(11, 32'd1);
        rd(6, d); check("R11 channel settings readback", d, 32'hA23A);
        run_for(13);
        rd(2, d); check("R6 reload period 5 after 15 clocks", d, 0);
        check("R9 toggle set clear keep", {28'd0, ext_match}, 32'hB);
        rd(4, d); check("R8 flags set", d, 32'hA);
        check("R8 irq high", {31'd0, irq}, 1);
        wr(4, 32'h0); rd(4, d); check("R8 write 0 keeps flags", d, 32'hA);
        wr(4, 32'h2); rd(4, d); check("R8 write 1 clears flag 1", d, 32'h8);
        check("R8 irq still high", {31'd0, irq}, 1);
        wr(4, 32'h8); rd(4, d); check("R8 all flags clear", d, 0);
        check("R8 irq low", {31'd0, irq}, 0);

        // R7 halt on match
        wr(6, 32'h04); wr(8, 32'd6);
        wr(0, 32'h2); wr(0, 32'h1);
        repeat (20) @(negedge clk);
        rd(2, d); check("R7 count holds at match", d, 6);
        rd(0, d); check("R7 run bit cleared", d, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule